// File: doc/BRIEF.md
# Eight-Phase Fractional Backup Clock Divider

This block derives a slow backup clock, near 32 kHz, from a faster RTC clock. It does not use a single integer divide ratio. Instead it cycles through eight programmable 4-bit half-period lengths. The output toggles at the end of each one, so one pass over all eight produces four full output periods. Because each length can be either M or M+1, the average output frequency can be set in steps finer than a whole divider step.

Software writes a 32-bit factor that holds the eight lengths and then asserts the enable. A new factor is picked up only when the phase index wraps, so a sequence already in progress is never mixed with new values. A combinational helper is included. It converts an RTC frequency in kHz into a factor that meets the sum and spread rules, and the result can be fed back into the factor input.

Top module: `backup_clk_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, clk_out is 0 and phase is 0.
- R2: While enable is low, clk_out stays 0 and phase stays 0, whatever value factor has.
- R3: Component i sits in factor bits [4i+3:4i], so x0 is bits 3:0. Counting from the first rising clock edge at which enable is sampled high, half-period i lasts exactly x_i clock cycles, and clk_out toggles at the end of each half-period.
- R4: phase gives the index of the half-period in progress. It advances by one at each toggle of clk_out and wraps from 7 to 0. While enabled, clk_out equals phase bit 0, so it is low in even phases.
- R5: A component of 0 gives a half-period of one cycle, so the output never stalls.
- R6: A factor written part way through a sequence does not affect the remaining phases of that sequence. It takes effect from phase 0 of the next sequence.
- R7: The calc_factor output is built as follows. M = floor(freq_khz/64) and S = floor(freq_khz/8). Every component starts at M, and the S-8M extra counts are added one each, starting at x0 and moving upward. Neighbouring components are therefore non-increasing and differ by at most 1.
- R8: A computed component that would exceed 15 is saturated to 15.
- R9: If enable falls part way through a half-period, then on the next cycle clk_out is 0 and phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider; when low, the outputs are held idle |
| factor | input | 32 | Eight packed 4-bit half-period lengths |
| freq_khz | input | 16 | RTC frequency in kHz, input to the factor helper |
| clk_out | output | 1 | Divided backup clock |
| phase | output | 3 | Index of the current half-period |
| calc_factor | output | 32 | Factor computed from freq_khz |

## Verification
The assertions assume that enable is low at reset release and changes only between clock edges, and that factor is either stable or changed away from the active edge. They also assume freq_khz stays below 1024 kHz, which keeps every computed step within one count. The bench changes all of its inputs only on falling edges, always releases reset with enable low, and draws its frequencies from a table inside that range, including one value that drives components into saturation.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int unsigned NUM_PH  = 8;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned FACT_W  = NUM_PH * NIB_W;
  localparam int unsigned PH_W    = $clog2(NUM_PH);
  localparam int unsigned FREQ_W  = 16;
  // frequency divisors for base component and for the component sum
  localparam int unsigned BASE_DIV = 64;
  localparam int unsigned SUM_DIV  = 8;
endpackage

// File: rtl/bclk_factor_calc.sv
module bclk_factor_calc #(
  parameter int unsigned NUM_PH   = bclk_pkg::NUM_PH,
  parameter int unsigned NIB_W    = bclk_pkg::NIB_W,
  parameter int unsigned FREQ_W   = bclk_pkg::FREQ_W,
  parameter int unsigned BASE_DIV = bclk_pkg::BASE_DIV,
  parameter int unsigned SUM_DIV  = bclk_pkg::SUM_DIV,
  localparam int unsigned FACT_W  = NUM_PH * NIB_W
) (
  input  logic [FREQ_W-1:0] freq_khz,
  output logic [FACT_W-1:0] factor_o
);
  localparam logic [FREQ_W:0] COMP_MAX = (FREQ_W+1)'((1 << NIB_W) - 1);

  logic [FREQ_W-1:0] base_m;
  logic [FREQ_W-1:0] sum_s;
  logic [FREQ_W-1:0] excess;

  always_comb begin
    base_m = freq_khz / FREQ_W'(BASE_DIV);
    sum_s  = freq_khz / FREQ_W'(SUM_DIV);
    excess = sum_s - (FREQ_W'(NUM_PH) * base_m);
  end

  // one component per phase: base plus one extra count for low indices
  for (genvar gi = 0; gi < NUM_PH; gi++) begin : g_comp
    logic [FREQ_W:0] raw_val;
    always_comb begin
      raw_val = {1'b0, base_m};
      if (FREQ_W'(gi) < excess) begin
        raw_val = raw_val + (FREQ_W+1)'(1);
      end
      if (raw_val > COMP_MAX) begin
        factor_o[gi*NIB_W +: NIB_W] = COMP_MAX[NIB_W-1:0];
      end else begin
        factor_o[gi*NIB_W +: NIB_W] = raw_val[NIB_W-1:0];
      end
    end
  end
endmodule

// File: rtl/bclk_phase_seq.sv
module bclk_phase_seq #(
  parameter int unsigned NUM_PH  = bclk_pkg::NUM_PH,
  parameter int unsigned NIB_W   = bclk_pkg::NIB_W,
  localparam int unsigned FACT_W = NUM_PH * NIB_W,
  localparam int unsigned PH_W   = $clog2(NUM_PH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              step,
  input  logic [FACT_W-1:0] factor_in,
  output logic [PH_W-1:0]   phase_o,
  output logic [NIB_W-1:0]  half_len
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_PH - 1);

  logic [PH_W-1:0]   phase_q, phase_d;
  logic [FACT_W-1:0] act_q;
  logic              load_en;
  logic [NIB_W-1:0]  comp_arr [NUM_PH];
  logic [NIB_W-1:0]  comp_sel;

  for (genvar gi = 0; gi < NUM_PH; gi++) begin : g_split
    assign comp_arr[gi] = act_q[gi*NIB_W +: NIB_W];
  end

  always_comb begin
    phase_d = phase_q;
    load_en = 1'b0;
    if (!run_en) begin
      phase_d = '0;
      load_en = 1'b1;
    end else if (step) begin
      if (phase_q == LAST_PH) begin
        phase_d = '0;
        load_en = 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (load_en) begin
      act_q <= factor_in;
    end
  end

  always_comb begin
    comp_sel = comp_arr[phase_q];
    if (comp_sel == '0) begin
      half_len = NIB_W'(1);
    end else begin
      half_len = comp_sel;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bclk_half_counter.sv
module bclk_half_counter #(
  parameter int unsigned NIB_W = bclk_pkg::NIB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [NIB_W-1:0] half_len,
  output logic             step,
  output logic             clk_o
);
  logic [NIB_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             at_end;

  assign at_end = (cnt_q == (half_len - 1'b1));
  assign step   = run_en && at_end;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (!run_en) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (at_end) begin
      cnt_d = '0;
      out_d = ~out_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_o = out_q;
endmodule

// File: rtl/backup_clk_gen.sv
module backup_clk_gen #(
  parameter int unsigned NUM_PH  = bclk_pkg::NUM_PH,
  parameter int unsigned NIB_W   = bclk_pkg::NIB_W,
  parameter int unsigned FREQ_W  = bclk_pkg::FREQ_W,
  localparam int unsigned FACT_W = NUM_PH * NIB_W,
  localparam int unsigned PH_W   = $clog2(NUM_PH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [FACT_W-1:0] factor,
  input  logic [FREQ_W-1:0] freq_khz,
  output logic              clk_out,
  output logic [PH_W-1:0]   phase,
  output logic [FACT_W-1:0] calc_factor
);
  logic             step;
  logic [NIB_W-1:0] half_len;

  bclk_phase_seq #(.NUM_PH(NUM_PH), .NIB_W(NIB_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (enable),
    .step      (step),
    .factor_in (factor),
    .phase_o   (phase),
    .half_len  (half_len)
  );

  bclk_half_counter #(.NIB_W(NIB_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (enable),
    .half_len (half_len),
    .step     (step),
    .clk_o    (clk_out)
  );

  bclk_factor_calc #(.NUM_PH(NUM_PH), .NIB_W(NIB_W), .FREQ_W(FREQ_W)) u_calc (
    .freq_khz (freq_khz),
    .factor_o (calc_factor)
  );
endmodule

// File: rtl/bclk_chk.sv
module bclk_chk #(
  parameter int unsigned NUM_PH  = bclk_pkg::NUM_PH,
  parameter int unsigned NIB_W   = bclk_pkg::NIB_W,
  parameter int unsigned FREQ_W  = bclk_pkg::FREQ_W,
  localparam int unsigned FACT_W = NUM_PH * NIB_W,
  localparam int unsigned PH_W   = $clog2(NUM_PH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [FACT_W-1:0] factor,
  input logic [FREQ_W-1:0] freq_khz,
  input logic              clk_out,
  input logic [PH_W-1:0]   phase,
  input logic [FACT_W-1:0] calc_factor
);
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (clk_out == 1'b0 && phase == '0));

  assert_out_is_phase_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out == phase[0]);

  assert_phase_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && enable) |->
      (phase == $past(phase) || phase == PH_W'($past(phase) + 1'b1)));

  assert_toggle_with_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && enable) |-> ($stable(clk_out) == $stable(phase)));

  for (genvar gi = 0; gi + 1 < NUM_PH; gi++) begin : g_steps
    assert_calc_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (calc_factor[gi*NIB_W +: NIB_W] == calc_factor[(gi+1)*NIB_W +: NIB_W]) ||
      (calc_factor[gi*NIB_W +: NIB_W] == calc_factor[(gi+1)*NIB_W +: NIB_W] + 1'b1));
  end
endmodule

bind backup_clk_gen bclk_chk #(.NUM_PH(NUM_PH), .NIB_W(NIB_W), .FREQ_W(FREQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .factor      (factor),
  .freq_khz    (freq_khz),
  .clk_out     (clk_out),
  .phase       (phase),
  .calc_factor (calc_factor)
);

// File: tb/backup_clk_gen_bench.sv
module backup_clk_gen_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;
  localparam int  NVEC       = 7;
  // {freq_khz, expected computed factor}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'd150,  32'h22222233},
    {16'd136,  32'h22222223},
    {16'd128,  32'h22222222},
    {16'd200,  32'h33333334},
    {16'd90,   32'h11111222},
    {16'd300,  32'h44455555},
    {16'd1016, 32'hFFFFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [31:0] factor;
  logic [15:0] freq_khz;
  logic        clk_out;
  logic [2:0]  phase;
  logic [31:0] calc_factor;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  backup_clk_gen u_backup_clk_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .factor      (factor),
    .freq_khz    (freq_khz),
    .clk_out     (clk_out),
    .phase       (phase),
    .calc_factor (calc_factor)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // measures half-periods first..last of one sequence; call at a negedge
  task automatic measure_halves(input logic [31:0] f, input int first, input int last,
                                input string req);
    for (int i = first; i <= last; i++) begin
      int   n    = 0;
      int   exp  = (f[i*4 +: 4] == 4'd0) ? 1 : int'(f[i*4 +: 4]);
      logic prev = clk_out;
      chk(phase == 3'(i), {req, " phase index"}, phase, i);
      do begin
        @(negedge clk);
        n++;
      end while (clk_out == prev && n < 40);
      chk(n == exp, {req, " half-period length"}, n, exp);
    end
  endtask

  task automatic run_sequence(input logic [31:0] f, input string req);
    @(negedge clk);
    enable = 1'b0;
    factor = f;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    measure_halves(f, 0, 7, req);
    chk(clk_out == 1'b0 && phase == 3'd0, {req, " end of sequence"}, {phase, clk_out}, 0);
    enable = 1'b0;
  endtask

  initial begin
    rst_n    = 1'b0;
    enable   = 1'b0;
    factor   = 32'h0;
    freq_khz = 16'd0;
    #(CLK_PERIOD*2 + 1ns);
    chk(clk_out == 1'b0 && phase == 3'd0, "R1 during reset", {phase, clk_out}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(clk_out == 1'b0 && phase == 3'd0, "R1 after release", {phase, clk_out}, 0);

    // table walk: helper result (R7/R8), then divider driven with it (R3/R4)
    for (int k = 0; k < NVEC; k++) begin
      freq_khz = VEC[k][47:32];
      @(negedge clk);
      chk(calc_factor == VEC[k][31:0], "R7 R8 computed factor", calc_factor, VEC[k][31:0]);
      run_sequence(VEC[k][31:0], "R3 R4 table sequence");
    end

    // R5: zero components last one cycle
    run_sequence(32'h0F0300A0, "R5 zero component");

    // R6: new factor mid-sequence applies from next wrap
    @(negedge clk);
    factor = 32'h22222222;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    measure_halves(32'h22222222, 0, 0, "R6 old factor");
    factor = 32'h33333333;
    measure_halves(32'h22222222, 1, 7, "R6 old factor kept");
    measure_halves(32'h33333333, 0, 7, "R6 new factor at wrap");

    // R9: enable drops mid half-period
    measure_halves(32'h33333333, 0, 0, "R9 lead-in");
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(clk_out == 1'b0 && phase == 3'd0, "R9 stop mid half-period", {phase, clk_out}, 0);

    // R2: factor changes while disabled have no effect at the outputs
    for (int j = 0; j < 6; j++) begin
      factor = 32'h11111111 * (j + 1);
      @(negedge clk);
      chk(clk_out == 1'b0 && phase == 3'd0, "R2 idle while disabled", {phase, clk_out}, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule